// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer that carries 36-bit words between two unrelated clock domains. The producer pushes words with its own clock and an active-low write enable. The consumer pulls them with a separate clock and an active-low read enable. The two clocks may have any frequency and any phase relationship. Binary write and read counters, one bit wider than the storage address, are turned into gray code and handed across the boundary through two-flop synchronisers. The empty and full decisions are made on those synchronised copies.

A mode input, captured while the master reset is active, selects how the output behaves. In standard mode the data output changes only when a read is requested, and the two status pins report empty (read side) and full (write side). In fall-through mode the oldest word is moved to the output on its own, and the status pins report output-ready and input-ready. The master reset clears both counters in every mode.

Top module: `dual_clock_fifo`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and the buffer is not full. Words leave in the order they were stored. Word width is 36 and depth is a power-of-two parameter (default 2048).
- R2: In standard mode, a rising `rd_clk` edge with `rd_en_n` at 0 and `rd_stat` at 0 (not empty) places the oldest word on `rd_data`. `rd_data` then holds that word until the next read.
- R3: In standard mode, a word written into an empty buffer does not reach `rd_data` without a read. `rd_data` keeps its previous value however long the bench waits.
- R4: In fall-through mode, the first word written into an empty buffer appears on `rd_data` with `rd_stat` at 1 right after the third rising `rd_clk` edge that follows the write edge. It has not appeared after the second such edge. No read enable is needed.
- R5: In fall-through mode, while `rd_en_n` is 1 the presented word and `rd_stat` stay unchanged. A rising `rd_clk` edge with `rd_en_n` at 0 and `rd_stat` at 1 consumes the presented word, and the next stored word follows.
- R6: A write attempted while the buffer is full is ignored. No word is stored and the write counter does not move.
- R7: A read attempted while the buffer is empty (standard mode), or while no word is presented (fall-through mode), is ignored. `rd_data` does not change and no later word is skipped.
- R8: Master reset (`rst_n` at 0) empties the buffer and clears `rd_data` to 0. In standard mode `rd_stat`=1 (empty) and `wr_stat`=0 (not full). In fall-through mode `rd_stat`=0 (not ready) and `wr_stat`=1 (ready for input).
- R9: `fall_thru`=1 selects fall-through mode and 0 selects standard mode. The value is taken only during master reset, so changing `fall_thru` afterwards has no effect.
- R10: Each pointer that crosses domains changes in at most one bit per edge of its own clock.
- R11: In standard mode, `wr_stat` becomes 1 right after DEPTH words have been stored with no reads. In fall-through mode `wr_stat` is 0 exactly when the storage is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assertion |
| fall_thru | input | 1 | Mode select, captured during reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 36 | Word to store |
| wr_stat | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 36 | Output word register |
| rd_stat | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |

## Verification
The assertions assume that `fall_thru` stays steady from the start of reset until two clock edges after release in each domain. They also assume that `wr_en_n` and `wr_data` change only away from rising `wr_clk` edges, and `rd_en_n` only away from rising `rd_clk` edges. The bench meets these conditions. It drives every input at a falling edge of its own domain, or a fixed delay after a rising one, and it changes the mode only while reset is held. The clock periods are chosen so that no write edge ever coincides with a read edge, which makes the three-edge fall-through latency count exactly.

// File: rtl/fifo_xclk_pkg.sv
package fifo_xclk_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_l
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_l = out_q;

endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_xclk_pkg::*;
#(
  parameter int AW = 11,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst_l,
  input  logic          mode_in,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rd_gray_ws,
  output logic [PW-1:0] wr_gray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full,
  output logic          mode_ft,
  output logic          wr_stat
);

  fifo_mode_e    mode_q;
  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic          push;

  // mode is loaded on every edge while the local reset is still held
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= MODE_STD;
    end else if (!rst_l) begin
      mode_q <= mode_in ? MODE_FWFT : MODE_STD;
    end
  end

  // full when the pointers differ only in the two top gray bits
  always_comb begin
    full = (gray_q == {~rd_gray_ws[PW-1:PW-2], rd_gray_ws[PW-3:0]});
    push = !wr_en_n && !full;
    bin_d  = bin_q + {{(PW-1){1'b0}}, push};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (push) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign wr_gray = gray_q;
  assign we      = push;
  assign waddr   = bin_q[AW-1:0];
  assign mode_ft = (mode_q == MODE_FWFT);
  assign wr_stat = mode_ft ? !full : full;

endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import fifo_xclk_pkg::*;
#(
  parameter int AW    = 11,
  parameter int WIDTH = 36,
  localparam int PW   = AW + 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_l,
  input  logic             mode_in,
  input  logic             rd_en_n,
  input  logic [PW-1:0]    wr_gray_rs,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [PW-1:0]    rd_gray,
  output logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             mode_ft,
  output logic             rd_stat
);

  fifo_mode_e       mode_q;
  logic [PW-1:0]    bin_q, bin_d;
  logic [PW-1:0]    gray_q, gray_d;
  logic             ready_q, ready_d;
  logic [WIDTH-1:0] dout_q;
  logic             fetch;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= MODE_STD;
    end else if (!rst_l) begin
      mode_q <= mode_in ? MODE_FWFT : MODE_STD;
    end
  end

  assign mode_ft = (mode_q == MODE_FWFT);

  always_comb begin
    empty = (gray_q == wr_gray_rs);
    if (mode_ft) begin
      // refill the output register when it is free or being consumed
      fetch = !empty && (!ready_q || !rd_en_n);
      if (fetch) begin
        ready_d = 1'b1;
      end else if (!rd_en_n) begin
        ready_d = 1'b0;
      end else begin
        ready_d = ready_q;
      end
    end else begin
      fetch   = !empty && !rd_en_n;
      ready_d = 1'b0;
    end
    bin_d  = bin_q + {{(PW-1){1'b0}}, fetch};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      bin_q  <= '0;
      gray_q <= '0;
      dout_q <= '0;
    end else if (fetch) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      dout_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign rd_gray = gray_q;
  assign raddr   = bin_q[AW-1:0];
  assign rd_data = dout_q;
  assign rd_stat = mode_ft ? ready_q : empty;

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             fall_thru,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_stat,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_stat
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_rst_l, rd_rst_l;
  logic [PW-1:0] wr_gray, rd_gray;
  logic [PW-1:0] wr_gray_rs, rd_gray_ws;
  logic          mem_we;
  logic [AW-1:0] waddr, raddr;
  logic [WIDTH-1:0] mem_rdata;
  logic          wr_full, rd_empty;
  logic          wr_ft, rd_ft;

  fifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .rst_l(wr_rst_l));
  fifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .rst_l(rd_rst_l));

  fifo_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_l(rd_rst_l), .d(wr_gray), .q(wr_gray_rs)
  );
  fifo_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_l(wr_rst_l), .d(rd_gray), .q(rd_gray_ws)
  );

  fifo_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .arst_n(rst_n), .rst_l(wr_rst_l), .mode_in(fall_thru),
    .wr_en_n(wr_en_n), .rd_gray_ws(rd_gray_ws), .wr_gray(wr_gray),
    .we(mem_we), .waddr(waddr), .full(wr_full), .mode_ft(wr_ft),
    .wr_stat(wr_stat)
  );

  fifo_rd_side #(.AW(AW), .WIDTH(WIDTH)) u_rd (
    .clk(rd_clk), .arst_n(rst_n), .rst_l(rd_rst_l), .mode_in(fall_thru),
    .rd_en_n(rd_en_n), .wr_gray_rs(wr_gray_rs), .mem_rdata(mem_rdata),
    .rd_gray(rd_gray), .raddr(raddr), .rd_data(rd_data), .empty(rd_empty),
    .mode_ft(rd_ft), .rd_stat(rd_stat)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

endmodule

// File: rtl/fifo_xclk_checker.sv
module fifo_xclk_checker #(
  parameter int PW    = 12,
  parameter int WIDTH = 36
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_en_n,
  input logic             rd_en_n,
  input logic             wr_full,
  input logic             rd_empty,
  input logic             rd_ft,
  input logic             rd_stat,
  input logic [WIDTH-1:0] rd_data,
  input logic [PW-1:0]    wr_gray,
  input logic [PW-1:0]    rd_gray
);

  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && !wr_en_n) |=> $stable(wr_gray));

  // R7
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |=> $stable(rd_gray));

  // R10
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R10
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  // R3
  std_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_ft && (rd_en_n || rd_empty)) |=> $stable(rd_data));

  // R5
  ft_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_ft && rd_stat && rd_en_n) |=> (rd_stat && $stable(rd_data)));

endmodule

bind dual_clock_fifo fifo_xclk_checker #(.PW(PW), .WIDTH(WIDTH)) i_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
  .rd_en_n(rd_en_n), .wr_full(wr_full), .rd_empty(rd_empty), .rd_ft(rd_ft),
  .rd_stat(rd_stat), .rd_data(rd_data), .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/test_dual_clock_fifo.sv
module test_dual_clock_fifo;

  localparam int W = 36;
  localparam int D = 16;

  logic         wr_clk, rd_clk, rst_n, fall_thru;
  logic         wr_en_n, rd_en_n;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         wr_stat, rd_stat;

  int  n_vec;
  int  n_bad;
  bit  done;

  dual_clock_fifo #(.WIDTH(W), .DEPTH(D)) i_dual_clock_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fall_thru(fall_thru),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_stat(wr_stat),
    .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_stat(rd_stat)
  );

  // 125 MHz write clock, 100 MHz read clock offset so edges never coincide
  initial begin
    wr_clk = 1'b0;
    forever #4 wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 1'b0;
    #2;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset(input logic ft);
    rst_n = 1'b0; fall_thru = ft; wr_en_n = 1'b1; rd_en_n = 1'b1; wr_data = '0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic wait_rd(input logic lvl);
    for (int i = 0; i < 50; i++) begin
      @(negedge rd_clk);
      if (rd_stat === lvl) break;
    end
  endtask

  // standard-mode read: wait for not empty, one read strobe, compare
  task automatic std_pop(input string req, input logic [W-1:0] exp);
    wait_rd(1'b0);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #1 rd_en_n = 1'b1;
    chk(req, rd_data, exp);
  endtask

  // fall-through read: wait for a presented word, compare, consume
  task automatic ft_pop(input string req, input logic [W-1:0] exp);
    wait_rd(1'b1);
    chk(req, rd_data, exp);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #1 rd_en_n = 1'b1;
  endtask

  task automatic t_reset_std();
    do_reset(1'b0);
    chk("R8 std rd_stat", {35'd0, rd_stat}, 36'd1);
    chk("R8 std wr_stat", {35'd0, wr_stat}, 36'd0);
    chk("R8 rd_data", rd_data, '0);
  endtask

  task automatic t_std_no_fall();
    push(36'h1_2345_6789);
    repeat (8) @(negedge rd_clk);
    chk("R3 no fall-through", rd_data, '0);
    chk("R3 flag not empty", {35'd0, rd_stat}, 36'd0);
    std_pop("R2 first read", 36'h1_2345_6789);
    repeat (2) @(negedge rd_clk);
    chk("R2 empty after", {35'd0, rd_stat}, 36'd1);
  endtask

  task automatic t_std_underflow();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    rd_en_n = 1'b1;
    chk("R7 data held", rd_data, 36'h1_2345_6789);
    push(36'hA_AAAA_0001);
    push(36'hA_AAAA_0002);
    std_pop("R7 no skip", 36'hA_AAAA_0001);
    std_pop("R1 order", 36'hA_AAAA_0002);
  endtask

  task automatic t_std_full();
    for (int i = 0; i < D; i++) begin
      chk("R11 not full yet", {35'd0, wr_stat}, 36'd0);
      push(36'h5_0000_0000 + 36'(i));
    end
    chk("R11 full", {35'd0, wr_stat}, 36'd1);
    push(36'hB_ADBA_DBAD);
    for (int i = 0; i < D; i++) begin
      std_pop("R6 R1 contents", 36'h5_0000_0000 + 36'(i));
    end
    repeat (2) @(negedge rd_clk);
    chk("R6 dropped write", {35'd0, rd_stat}, 36'd1);
    repeat (4) @(negedge wr_clk);
    chk("R11 full clears", {35'd0, wr_stat}, 36'd0);
  endtask

  task automatic t_mode_late();
    @(negedge wr_clk);
    fall_thru = 1'b1;
    push(36'hC_0FFE_E000);
    repeat (8) @(negedge rd_clk);
    chk("R9 still standard", rd_data, 36'h5_0000_000F);
    std_pop("R9 read", 36'hC_0FFE_E000);
  endtask

  task automatic t_reset_ft();
    do_reset(1'b1);
    chk("R8 ft rd_stat", {35'd0, rd_stat}, 36'd0);
    chk("R8 ft wr_stat", {35'd0, wr_stat}, 36'd1);
    chk("R8 ft rd_data", rd_data, '0);
  endtask

  task automatic t_ft_latency();
    logic r2;
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_data = 36'hF_1111_0001;
    @(posedge wr_clk);
    wr_en_n <= 1'b1;
    @(posedge rd_clk);
    @(posedge rd_clk);
    #1 r2 = rd_stat;
    chk("R4 not after edge 2", {35'd0, r2}, 36'd0);
    @(posedge rd_clk);
    #1;
    chk("R4 ready after edge 3", {35'd0, rd_stat}, 36'd1);
    chk("R4 word", rd_data, 36'hF_1111_0001);
  endtask

  task automatic t_ft_hold_stream();
    for (int i = 2; i < 6; i++) push(36'hF_1111_0000 + 36'(i));
    repeat (6) @(negedge rd_clk);
    chk("R5 held", rd_data, 36'hF_1111_0001);
    for (int i = 1; i < 6; i++) ft_pop("R5 stream", 36'hF_1111_0000 + 36'(i));
    repeat (3) @(negedge rd_clk);
    chk("R5 drained", {35'd0, rd_stat}, 36'd0);
  endtask

  task automatic t_ft_underflow();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    chk("R7 ft data held", rd_data, 36'hF_1111_0005);
    rd_en_n = 1'b1;
    push(36'h7_7777_7777);
    ft_pop("R7 ft no skip", 36'h7_7777_7777);
  endtask

  task automatic t_ft_full();
    for (int i = 0; i < D; i++) push(36'h3_0000_0000 + 36'(i));
    repeat (6) @(negedge wr_clk);
    chk("R11 ft room for one", {35'd0, wr_stat}, 36'd1);
    push(36'h3_0000_0010);
    chk("R11 ft input not ready", {35'd0, wr_stat}, 36'd0);
    push(36'hB_ADBA_DBAD);
    for (int i = 0; i <= D; i++) ft_pop("R6 ft contents", 36'h3_0000_0000 + 36'(i));
    repeat (4) @(negedge rd_clk);
    chk("R6 ft dropped", {35'd0, rd_stat}, 36'd0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    t_reset_std();
    t_std_no_fall();
    t_std_underflow();
    t_std_full();
    t_mode_late();
    t_reset_ft();
    t_ft_latency();
    t_ft_hold_stream();
    t_ft_underflow();
    t_ft_full();
    finish_run();
  end

  initial begin
    #400000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

endmodule